// File: doc/BRIEF.md
# Eight-Bit ALU with Parallel Status Flags

This block is an arithmetic-logic unit for two unsigned/two's-complement operands of parameterised width (eight bits by default). A two-bit operation select picks one of four results: the sum, the difference, the low half of the product, or the bitwise AND. Alongside the result it reports six status flags: zero, negative, carry, borrow, signed overflow of the addition and signed overflow of the subtraction.

The flag logic does not look at the operation select. Carry, borrow and both overflow flags always describe the sum and the difference of the current operands. Zero and negative always describe whichever result was selected. Subtraction uses a second instance of the same ripple-carry adder, fed with the inverted B operand and a carry-in of one.

The operands and the select are combined in one cycle. The result and all flags are captured in output registers, so the outputs appear one clock after the inputs are applied. A synchronous active-high reset clears those registers.

Top module: `alu_flags_core`

## Requirements
- R1: While `rst` is high at a rising clock edge, `res_q` and all six flag outputs become 0 after that edge.
- R2: With `op_sel` = 2'b00, `res_q` one cycle later equals (A + B) mod 2^W.
- R3: With `op_sel` = 2'b01, `res_q` one cycle later equals (A - B) mod 2^W.
- R4: With `op_sel` = 2'b10, `res_q` one cycle later equals the low W bits of the 2W-bit product A*B.
- R5: With `op_sel` = 2'b11, `res_q` one cycle later equals A & B.
- R6: For any `op_sel`, `carry_q` is the carry out of the most significant bit of A + B.
- R7: For any `op_sel`, `borrow_q` is the complement of that carry out, so exactly one of `carry_q` and `borrow_q` is set after each non-reset cycle.
- R8: For any `op_sel`, `ovf_add_q` is 1 exactly when A and B have equal sign bits and the sign bit of (A + B) mod 2^W differs from them.
- R9: For any `op_sel`, `ovf_sub_q` is 1 exactly when the sign bits of A and B differ and the sign bit of (A - B) mod 2^W differs from the sign bit of A.
- R10: `neg_q` equals bit W-1 of `res_q`. `zero_q` is 1 exactly when every bit of `res_q` is 0. Both refer to the result that was selected.
- R11: With W = 8, the inputs A = 0x72, B = 0x18 and `op_sel` = 2'b00 give `res_q` = 0x8A, `zero_q` = 0, `neg_q` = 1, `ovf_sub_q` = 0, `ovf_add_q` = 1, `borrow_q` = 1 and `carry_q` = 0.
- R12: With A = B = 0, every operation gives `res_q` = 0 and `zero_q` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs update on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| op_sel | input | 2 | Operation: 00 add, 01 subtract, 10 multiply (low half), 11 AND |
| opnd_a | input | W | First operand A |
| opnd_b | input | W | Second operand B |
| res_q | output | W | Registered result of the selected operation |
| carry_q | output | 1 | Carry out of A + B |
| borrow_q | output | 1 | Complement of the carry out of A + B |
| ovf_add_q | output | 1 | Signed overflow of A + B |
| ovf_sub_q | output | 1 | Signed overflow of A - B |
| neg_q | output | 1 | Sign bit of the registered result |
| zero_q | output | 1 | Registered result is all zeros |

## Verification
The bench sweeps every pair of 8-bit operands and rotates the operation select across the sweep, so every flag is compared on the full operand space. This exposes flags that only update for the matching operation, and overflow logic that uses the wrong sign bit. It targets the sign boundaries 0x7F/0x80, the all-ones operand, and the zero-result cases after subtraction of equal values and after multiplications that wrap to zero (such as 0x10 * 0x10). A design that dropped the inverted-B carry-in would be one off on every difference. A multiplier that lost its truncation or shifted a partial product wrongly would fail on high-bit products. A zero flag wired to the sum instead of the selected result would fire on AND results. The documented 114 + 24 case and reset in mid-sweep are also checked.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_MUL = 2'b10,
    OP_AND = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic carry;
    logic borrow;
    logic ovf_add;
    logic ovf_sub;
    logic neg;
    logic zero;
  } alu_flags_t;

endpackage

// File: rtl/alu_ripple_add.sv
module alu_ripple_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         c_into_msb
);

  logic [W:0] cy;

  assign cy[0] = cin;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      assign sum[i]  = a[i] ^ b[i] ^ cy[i];
      assign cy[i+1] = (a[i] & b[i]) | (cy[i] & (a[i] ^ b[i]));
    end
  endgenerate

  assign cout       = cy[W];
  assign c_into_msb = cy[W-1];

endmodule

// File: rtl/alu_mul_lo.sv
module alu_mul_lo #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] prod_lo
);

  logic [W-1:0] acc [0:W];

  assign acc[0] = '0;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_pp
      logic [W-1:0] part;
      assign part     = b[i] ? (a << i) : '0;
      assign acc[i+1] = acc[i] + part;
    end
  endgenerate

  assign prod_lo = acc[W];

endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
  import alu_flags_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] res,
  input  logic         add_cout,
  input  logic         add_cmsb,
  input  logic         sub_cout,
  input  logic         sub_cmsb,
  output alu_flags_t   flags
);

  always_comb begin
    flags.carry   = add_cout;
    flags.borrow  = ~add_cout;
    flags.ovf_add = add_cout ^ add_cmsb;
    flags.ovf_sub = sub_cout ^ sub_cmsb;
    flags.neg     = res[W-1];
    flags.zero    = ~|res;
  end

endmodule

// File: rtl/alu_flags_core.sv
module alu_flags_core
  import alu_flags_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   op_sel,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic [W-1:0] res_q,
  output logic         carry_q,
  output logic         borrow_q,
  output logic         ovf_add_q,
  output logic         ovf_sub_q,
  output logic         neg_q,
  output logic         zero_q
);

  logic [W-1:0] sum_w, diff_w, prod_w, and_w, res_d;
  logic         add_co, add_cm, sub_co, sub_cm;
  alu_op_e      op;
  alu_flags_t   flg_d, flg_q;

  assign op    = alu_op_e'(op_sel);
  assign and_w = opnd_a & opnd_b;

  alu_ripple_add #(.W(W)) u_add (
    .a(opnd_a), .b(opnd_b), .cin(1'b0),
    .sum(sum_w), .cout(add_co), .c_into_msb(add_cm)
  );

  alu_ripple_add #(.W(W)) u_sub (
    .a(opnd_a), .b(~opnd_b), .cin(1'b1),
    .sum(diff_w), .cout(sub_co), .c_into_msb(sub_cm)
  );

  alu_mul_lo #(.W(W)) u_mul (
    .a(opnd_a), .b(opnd_b), .prod_lo(prod_w)
  );

  always_comb begin
    unique case (op)
      OP_ADD:  res_d = sum_w;
      OP_SUB:  res_d = diff_w;
      OP_MUL:  res_d = prod_w;
      default: res_d = and_w;
    endcase
  end

  alu_flag_gen #(.W(W)) u_flags (
    .res(res_d),
    .add_cout(add_co), .add_cmsb(add_cm),
    .sub_cout(sub_co), .sub_cmsb(sub_cm),
    .flags(flg_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      flg_q <= '0;
    end else begin
      res_q <= res_d;
      flg_q <= flg_d;
    end
  end

  assign carry_q   = flg_q.carry;
  assign borrow_q  = flg_q.borrow;
  assign ovf_add_q = flg_q.ovf_add;
  assign ovf_sub_q = flg_q.ovf_sub;
  assign neg_q     = flg_q.neg;
  assign zero_q    = flg_q.zero;

endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   op_sel,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic [W-1:0] res_q,
  input logic         carry_q,
  input logic         borrow_q,
  input logic         ovf_add_q,
  input logic         ovf_sub_q,
  input logic         neg_q,
  input logic         zero_q
);

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (res_q == '0 && !carry_q && !borrow_q && !ovf_add_q
                    && !ovf_sub_q && !neg_q && !zero_q));

  a_r5_and_result: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_sel) == 2'b11) |-> res_q == ($past(opnd_a) & $past(opnd_b)));

  a_r3_sub_result: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_sel) == 2'b01) |-> (res_q + $past(opnd_b)) == $past(opnd_a));

  a_r7_borrow_inverse: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $countones({carry_q, borrow_q}) == 1);

  a_r8_add_ovf: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(opnd_a[W-1]) != $past(opnd_b[W-1])) |-> !ovf_add_q);

  a_r9_sub_ovf: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(opnd_a[W-1]) == $past(opnd_b[W-1])) |-> !ovf_sub_q);

  a_r10_neg_msb: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> neg_q == res_q[W-1]);

  a_r10_zero_all: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> zero_q == (res_q == '0));

endmodule

bind alu_flags_core alu_flags_chk #(.W(W)) u_chk (.*);

// File: tb/alu_flags_core_test.sv
module alu_flags_core_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] op_sel = 2'b00;
  logic [7:0] opnd_a = 8'h00;
  logic [7:0] opnd_b = 8'h00;
  logic [7:0] res_q;
  logic carry_q, borrow_q, ovf_add_q, ovf_sub_q, neg_q, zero_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  alu_flags_core #(.W(8)) uut (
    .clk(clk), .rst(rst), .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .res_q(res_q), .carry_q(carry_q), .borrow_q(borrow_q),
    .ovf_add_q(ovf_add_q), .ovf_sub_q(ovf_sub_q), .neg_q(neg_q), .zero_q(zero_q)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (a=%0h b=%0h op=%0d)",
               req, act, exp, opnd_a, opnd_b, op_sel);
    end
  endtask

  // Apply one vector at the falling edge, sample 1 ns after the next rising edge.
  task automatic apply(input int a, input int b, input int op);
    @(negedge clk);
    opnd_a = a[7:0];
    opnd_b = b[7:0];
    op_sel = op[1:0];
    @(posedge clk);
    #1;
  endtask

  task automatic check_all(input int a, input int b, input int op);
    int sum, dif, res, ea, eb, es, ed;
    sum = a + b;
    dif = (a - b) & 8'hFF;
    case (op)
      0: res = sum & 8'hFF;
      1: res = dif;
      2: res = (a * b) & 8'hFF;
      default: res = a & b;
    endcase
    ea = (a >> 7) & 1;
    eb = (b >> 7) & 1;
    es = (sum >> 7) & 1;
    ed = (dif >> 7) & 1;
    case (op)
      0: chk("R2 add", res_q, res);
      1: chk("R3 sub", res_q, res);
      2: chk("R4 mul", res_q, res);
      default: chk("R5 and", res_q, res);
    endcase
    chk("R6 carry", carry_q, (sum >> 8) & 1);
    chk("R7 borrow", borrow_q, ((sum >> 8) & 1) ^ 1);
    chk("R8 ovf_add", ovf_add_q, (ea == eb && es != ea) ? 1 : 0);
    chk("R9 ovf_sub", ovf_sub_q, (ea != eb && ed != ea) ? 1 : 0);
    chk("R10 neg", neg_q, (res >> 7) & 1);
    chk("R10 zero", zero_q, (res == 0) ? 1 : 0);
  endtask

  task automatic check_reset_state();
    chk("R1 res", res_q, 0);
    chk("R1 flags", {carry_q, borrow_q, ovf_add_q, ovf_sub_q, neg_q, zero_q}, 0);
  endtask

  initial begin
    // R1: reset with busy inputs still clears every output
    @(negedge clk);
    rst = 1'b1;
    opnd_a = 8'hFF;
    opnd_b = 8'h01;
    op_sel = 2'b00;
    @(posedge clk);
    #1;
    check_reset_state();
    @(negedge clk);
    rst = 1'b0;

    // R12: zero operands on every operation
    for (int op = 0; op < 4; op++) begin
      apply(0, 0, op);
      chk("R12 res", res_q, 0);
      chk("R12 zero", zero_q, 1);
    end

    // R11: documented example 114 + 24
    apply(8'h72, 8'h18, 0);
    chk("R11 res", res_q, 8'h8A);
    chk("R11 zero", zero_q, 0);
    chk("R11 neg", neg_q, 1);
    chk("R11 ovf_sub", ovf_sub_q, 0);
    chk("R11 ovf_add", ovf_add_q, 1);
    chk("R11 borrow", borrow_q, 1);
    chk("R11 carry", carry_q, 0);

    // Directed boundary vectors on all operations
    begin
      int dv [0:7][0:1];
      dv = '{'{8'h7F, 8'h01}, '{8'h80, 8'h01}, '{8'h80, 8'h80}, '{8'hFF, 8'hFF},
             '{8'h10, 8'h10}, '{8'h55, 8'h55}, '{8'h00, 8'h80}, '{8'h7F, 8'h80}};
      for (int k = 0; k < 8; k++)
        for (int op = 0; op < 4; op++) begin
          apply(dv[k][0], dv[k][1], op);
          check_all(dv[k][0], dv[k][1], op);
        end
    end

    // Exhaustive operand sweep with a rotating select
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++) begin
        int op;
        op = ((a & 3) + ((b >> 2) & 3)) & 3;
        apply(a, b, op);
        check_all(a, b, op);
      end

    // R1: reset in mid-run
    @(negedge clk);
    rst = 1'b1;
    opnd_a = 8'h80;
    opnd_b = 8'h80;
    @(posedge clk);
    #1;
    check_reset_state();
    @(negedge clk);
    rst = 1'b0;
    apply(8'h80, 8'h80, 1);
    check_all(8'h80, 8'h80, 1);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule